// File: doc/BRIEF.md
# Multi-Mode Interrupt Entry Controller

This block decides when an 8-bit processor core leaves its instruction stream for an interrupt handler, and it works out where that handler is. It takes one edge-triggered non-maskable request and one level-sensitive maskable request. It holds a main enable flag and a shadow enable flag. At each instruction boundary that the core reports, it either stays idle or starts an entry sequence. During that sequence it can raise an acknowledge cycle, push the return address, read a two-entry vector table, and load the program counter.

Maskable entry has three forms, chosen by a mode select that is latched when the request is accepted:
- **Mode 0:** the acknowledging device supplies an instruction byte. The controller hands that byte back to the core and does nothing else.
- **Mode 1:** control goes to a fixed handler address.
- **Mode 2:** a page register and a device byte form a table address, and the handler address is read from the table.

Non-maskable entry always goes to its own fixed address. It saves the main enable flag into the shadow flag, so that a return command can restore the flag later.

The controller is a single state machine with these states:

| State | What it does | Next state |
|---|---|---|
| IDLE | Evaluates commands and boundaries. | NMI entry: PUSH_HI. Maskable entry: ACK. |
| ACK | Runs the acknowledge cycle and samples the device byte. | Mode 0: RST. Otherwise: PUSH_HI. |
| PUSH_HI | Pushes the high byte of the return address. | PUSH_LO |
| PUSH_LO | Pushes the low byte of the return address. | Mode 2 maskable entry: TBL_LO. Otherwise: LOAD. |
| TBL_LO | Reads the low byte of the handler address from the table. | TBL_HI |
| TBL_HI | Reads the high byte of the handler address from the table. | LOAD |
| LOAD | Gives the handler address to the core. | IDLE |
| RST | Hands the instruction byte back to the core. | IDLE |

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both enable flags are 0, `busy` is 0 and every strobe, address and data output is 0.
- R2: A rising edge on `nmi_req` sets a pending non-maskable request, which stays set until the next accepted instruction boundary. A level held high does not retrigger. An edge seen while an entry is in progress stays pending. The non-maskable request wins over a maskable request at the same boundary.
- R3: Non-maskable entry copies the main flag into the shadow flag and clears the main flag. It pushes the return address and loads 0x0066 as the program counter.
- R4: A maskable request is taken only at an idle boundary with the main flag at 1 and no enable hold-off. Taking it clears both flags. A handler address is never loaded while the main flag is 1.
- R5: Every maskable entry starts with one cycle in which `ack_io_req` and `ack_opfetch` are both 1. The device byte on `bus_data` is sampled in that cycle.
- R6: With `im_sel` = 0, the cycle after the acknowledge cycle raises `insn_valid` with the sampled byte on `insn_byte`. No push and no program counter load take place.
- R7: With `im_sel` = 1, the return address (`pc_cur` at acceptance) is pushed high byte first and then low byte, one byte per cycle. The program counter is then loaded with 0x0038.
- R8: With `im_sel` = 2 or 3, the pushes are followed by a table read of the low byte at {`page_reg`, device byte with bit 0 forced to 0}. The next cycle reads the high byte at that address plus 1. The two bytes are then loaded as the program counter.
- R9: An enable command sets both flags. The instruction boundary that follows the command does not accept a maskable request.
- R10: A disable command clears both flags. A return-from-NMI command copies the shadow flag into the main flag.
- R11: Boundaries and commands are ignored while `busy` is 1. Each entry cycle raises exactly one of acknowledge, push, table read, load and byte hand-back. Every entry ends in IDLE on the cycle after its load or hand-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| int_req | input | 1 | Maskable request, level-sensitive |
| insn_boundary | input | 1 | High for one cycle when the core ends an instruction |
| ei_cmd | input | 1 | Enable command |
| di_cmd | input | 1 | Disable command |
| nmi_return | input | 1 | Return-from-NMI command |
| im_sel | input | 2 | Maskable mode: 0, 1, or 2 (3 behaves as 2) |
| page_reg | input | 8 | High byte of the mode 2 table address |
| bus_data | input | 8 | Device byte during the acknowledge cycle; table data during reads |
| pc_cur | input | 16 | Program counter at the boundary |
| busy | output | 1 | An entry sequence is in progress |
| en_main | output | 1 | Main enable flag |
| en_shadow | output | 1 | Shadow enable flag |
| ack_io_req | output | 1 | Acknowledge cycle: I/O request strobe |
| ack_opfetch | output | 1 | Acknowledge cycle: first-machine-cycle strobe |
| push_req | output | 1 | Push one return-address byte |
| push_data | output | 8 | Byte to push |
| tbl_rd | output | 1 | Vector table read strobe |
| tbl_addr | output | 16 | Vector table read address |
| pc_load | output | 1 | Load the program counter |
| pc_new | output | 16 | Handler address |
| insn_valid | output | 1 | Mode 0 instruction byte is valid |
| insn_byte | output | 8 | Mode 0 instruction byte |

## Verification
The assertions check properties of every entry on every cycle:
- the acknowledge cycle lasts one cycle;
- the two pushes come back to back;
- the table reads start on an even address and step by one;
- no handler address is loaded with the main flag set;
- only one action strobe is raised per cycle;
- the controller returns to IDLE after the final step.

Some behaviours can only be shown by the bench scenarios, through its reference model:
- the hold-off after an enable command;
- the priority of the non-maskable request, and its edge memory across a busy period;
- the saving and restoring of the flags;
- the pushed bytes, the table contents and the handler address in each mode;
- that commands are ignored while busy.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int DW = 8;
    localparam int AW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_TBL_LO,
        ST_TBL_HI,
        ST_LOAD,
        ST_RST
    } irqv_state_e;

    typedef enum logic [1:0] {
        MD_INSN  = 2'd0,
        MD_FIXED = 2'd1,
        MD_TABLE = 2'd2
    } irqv_mode_e;
endpackage

// File: rtl/irqv_nmi_edge.sv
module irqv_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take_nmi,
    output logic nmi_pend
);
    logic nmi_prev;

    // Rising edge is remembered until an entry consumes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_req;
            nmi_pend <= (nmi_pend & ~take_nmi) | (nmi_req & ~nmi_prev);
        end
    end
endmodule

// File: rtl/irqv_enable_ff.sv
module irqv_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic boundary,
    input  logic take_nmi,
    input  logic take_int,
    input  logic ei_cmd,
    input  logic di_cmd,
    input  logic nmi_return,
    output logic en_main,
    output logic en_shadow,
    output logic ei_hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_main   <= 1'b0;
            en_shadow <= 1'b0;
            ei_hold   <= 1'b0;
        end else if (idle) begin
            if (take_nmi) begin
                en_shadow <= en_main;
                en_main   <= 1'b0;
            end else if (take_int) begin
                en_main   <= 1'b0;
                en_shadow <= 1'b0;
            end else if (ei_cmd) begin
                en_main   <= 1'b1;
                en_shadow <= 1'b1;
            end else if (di_cmd) begin
                en_main   <= 1'b0;
                en_shadow <= 1'b0;
            end else if (nmi_return) begin
                en_main   <= en_shadow;
            end
            // hold-off spans exactly one boundary after an enable command
            if (ei_cmd) begin
                ei_hold <= 1'b1;
            end else if (boundary) begin
                ei_hold <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
    import irqv_pkg::*;
#(
    parameter logic [AW-1:0] NMI_TARGET   = 16'h0066,
    parameter logic [AW-1:0] FIXED_TARGET = 16'h0038
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_nmi,
    input  logic          start_int,
    input  logic [1:0]    im_sel,
    input  logic [DW-1:0] page_reg,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] pc_cur,
    output logic          idle,
    output logic          ack_io_req,
    output logic          ack_opfetch,
    output logic          push_req,
    output logic [DW-1:0] push_data,
    output logic          tbl_rd,
    output logic [AW-1:0] tbl_addr,
    output logic          pc_load,
    output logic [AW-1:0] pc_new,
    output logic          insn_valid,
    output logic [DW-1:0] insn_byte
);
    irqv_state_e   state_q, state_d;
    irqv_mode_e    mode_q;
    logic          nmi_q;
    logic [AW-1:0] ret_q;
    logic [DW-1:0] page_q, vec_q, lo_q, hi_q;
    logic [AW-1:0] tbl_base;

    assign tbl_base = {page_q, vec_q[DW-1:1], 1'b0};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_nmi) begin
                    state_d = ST_PUSH_HI;
                end else if (start_int) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK:     state_d = (mode_q == MD_INSN) ? ST_RST : ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = (!nmi_q && mode_q == MD_TABLE) ? ST_TBL_LO : ST_LOAD;
            ST_TBL_LO:  state_d = ST_TBL_HI;
            ST_TBL_HI:  state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            ST_RST:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // data captured along the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_INSN;
            nmi_q  <= 1'b0;
            ret_q  <= '0;
            page_q <= '0;
            vec_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && (start_nmi || start_int)) begin
                nmi_q  <= start_nmi;
                ret_q  <= pc_cur;
                page_q <= page_reg;
                mode_q <= (im_sel == 2'd0) ? MD_INSN :
                          ((im_sel == 2'd1) ? MD_FIXED : MD_TABLE);
            end
            if (state_q == ST_ACK) begin
                vec_q <= bus_data;
            end
            if (state_q == ST_TBL_LO) begin
                lo_q <= bus_data;
            end
            if (state_q == ST_TBL_HI) begin
                hi_q <= bus_data;
            end
        end
    end

    // outputs
    always_comb begin
        idle        = 1'b0;
        ack_io_req  = 1'b0;
        ack_opfetch = 1'b0;
        push_req    = 1'b0;
        push_data   = '0;
        tbl_rd      = 1'b0;
        tbl_addr    = '0;
        pc_load     = 1'b0;
        pc_new      = '0;
        insn_valid  = 1'b0;
        insn_byte   = '0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_ACK: begin
                ack_io_req  = 1'b1;
                ack_opfetch = 1'b1;
            end
            ST_PUSH_HI: begin
                push_req  = 1'b1;
                push_data = ret_q[AW-1:DW];
            end
            ST_PUSH_LO: begin
                push_req  = 1'b1;
                push_data = ret_q[DW-1:0];
            end
            ST_TBL_LO: begin
                tbl_rd   = 1'b1;
                tbl_addr = tbl_base;
            end
            ST_TBL_HI: begin
                tbl_rd   = 1'b1;
                tbl_addr = tbl_base | {{(AW-1){1'b0}}, 1'b1};
            end
            ST_LOAD: begin
                pc_load = 1'b1;
                if (nmi_q) begin
                    pc_new = NMI_TARGET;
                end else if (mode_q == MD_FIXED) begin
                    pc_new = FIXED_TARGET;
                end else begin
                    pc_new = {hi_q, lo_q};
                end
            end
            ST_RST: begin
                insn_valid = 1'b1;
                insn_byte  = vec_q;
            end
            default: idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter logic [AW-1:0] NMI_TARGET   = 16'h0066,
    parameter logic [AW-1:0] FIXED_TARGET = 16'h0038
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          int_req,
    input  logic          insn_boundary,
    input  logic          ei_cmd,
    input  logic          di_cmd,
    input  logic          nmi_return,
    input  logic [1:0]    im_sel,
    input  logic [DW-1:0] page_reg,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] pc_cur,
    output logic          busy,
    output logic          en_main,
    output logic          en_shadow,
    output logic          ack_io_req,
    output logic          ack_opfetch,
    output logic          push_req,
    output logic [DW-1:0] push_data,
    output logic          tbl_rd,
    output logic [AW-1:0] tbl_addr,
    output logic          pc_load,
    output logic [AW-1:0] pc_new,
    output logic          insn_valid,
    output logic [DW-1:0] insn_byte
);
    logic idle, nmi_pend, ei_hold, take_nmi, take_int;

    assign take_nmi = idle & insn_boundary & nmi_pend;
    assign take_int = idle & insn_boundary & ~nmi_pend & en_main & int_req & ~ei_hold;
    assign busy     = ~idle;

    irqv_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .take_nmi (take_nmi),
        .nmi_pend (nmi_pend)
    );

    irqv_enable_ff u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .boundary   (insn_boundary),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .ei_cmd     (ei_cmd),
        .di_cmd     (di_cmd),
        .nmi_return (nmi_return),
        .en_main    (en_main),
        .en_shadow  (en_shadow),
        .ei_hold    (ei_hold)
    );

    irqv_seq #(
        .NMI_TARGET   (NMI_TARGET),
        .FIXED_TARGET (FIXED_TARGET)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_nmi   (take_nmi),
        .start_int   (take_int),
        .im_sel      (im_sel),
        .page_reg    (page_reg),
        .bus_data    (bus_data),
        .pc_cur      (pc_cur),
        .idle        (idle),
        .ack_io_req  (ack_io_req),
        .ack_opfetch (ack_opfetch),
        .push_req    (push_req),
        .push_data   (push_data),
        .tbl_rd      (tbl_rd),
        .tbl_addr    (tbl_addr),
        .pc_load     (pc_load),
        .pc_new      (pc_new),
        .insn_valid  (insn_valid),
        .insn_byte   (insn_byte)
    );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        en_main,
    input logic        ack_io_req,
    input logic        push_req,
    input logic        tbl_rd,
    input logic [15:0] tbl_addr,
    input logic        pc_load,
    input logic        insn_valid
);
    a_r5_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_io_req |=> !ack_io_req);

    a_r7_push_second: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !$past(push_req)) |=> push_req);

    a_r7_push_only_two: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && $past(push_req)) |=> !push_req);

    a_r8_tbl_even_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && !$past(tbl_rd)) |-> !tbl_addr[0]);

    a_r8_tbl_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && !$past(tbl_rd)) |=> (tbl_rd && tbl_addr == $past(tbl_addr) + 16'd1));

    a_r4_load_masked: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !en_main);

    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_io_req, push_req, tbl_rd, pc_load, insn_valid}));

    a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || insn_valid) |=> !busy);
endmodule

bind irq_vector_ctrl irqv_checker u_irqv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .en_main    (en_main),
    .ack_io_req (ack_io_req),
    .push_req   (push_req),
    .tbl_rd     (tbl_rd),
    .tbl_addr   (tbl_addr),
    .pc_load    (pc_load),
    .insn_valid (insn_valid)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req = 0, int_req = 0, insn_boundary = 0;
    logic ei_cmd = 0, di_cmd = 0, nmi_return = 0;
    logic [1:0]  im_sel = 0;
    logic [7:0]  page_reg = 0, vec_byte = 0;
    logic [15:0] pc_cur = 0;
    wire  [7:0]  bus_data;
    logic busy, en_main, en_shadow, ack_io_req, ack_opfetch, push_req, tbl_rd, pc_load, insn_valid;
    logic [7:0]  push_data, insn_byte;
    logic [15:0] tbl_addr, pc_new;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_data = tbl_rd ? mem_byte(tbl_addr) : vec_byte;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .int_req(int_req),
        .insn_boundary(insn_boundary), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .nmi_return(nmi_return), .im_sel(im_sel), .page_reg(page_reg),
        .bus_data(bus_data), .pc_cur(pc_cur), .busy(busy), .en_main(en_main),
        .en_shadow(en_shadow), .ack_io_req(ack_io_req), .ack_opfetch(ack_opfetch),
        .push_req(push_req), .push_data(push_data), .tbl_rd(tbl_rd),
        .tbl_addr(tbl_addr), .pc_load(pc_load), .pc_new(pc_new),
        .insn_valid(insn_valid), .insn_byte(insn_byte)
    );

    typedef struct packed {
        logic        busy;
        logic        ackio;
        logic        ackm1;
        logic        push;
        logic [7:0]  pdata;
        logic        rd;
        logic [15:0] raddr;
        logic        load;
        logic [15:0] pcnew;
        logic        rv;
        logic [7:0]  rbyte;
    } exp_t;

    exp_t q[$];
    logic m_main = 0, m_shadow = 0, m_hold = 0, m_pend = 0, m_prev = 0;
    int checks = 0, fails = 0, cyc = 0;
    bit running = 0, done = 0;
    string cur_req = "R1";

    function automatic exp_t busy_rec();
        exp_t e = '0;
        e.busy = 1'b1;
        return e;
    endfunction

    function automatic void enq_push(input logic [15:0] pc);
        exp_t e = busy_rec();
        e.push = 1'b1; e.pdata = pc[15:8]; q.push_back(e);
        e.pdata = pc[7:0]; q.push_back(e);
    endfunction

    function automatic void enq_load(input logic [15:0] t);
        exp_t e = busy_rec();
        e.load = 1'b1; e.pcnew = t; q.push_back(e);
    endfunction

    function automatic void enq_ack();
        exp_t e = busy_rec();
        e.ackio = 1'b1; e.ackm1 = 1'b1; q.push_back(e);
    endfunction

    function automatic void enq_int();
        exp_t e;
        logic [15:0] base;
        enq_ack();
        if (im_sel == 2'd0) begin
            e = busy_rec(); e.rv = 1'b1; e.rbyte = vec_byte; q.push_back(e);
        end else if (im_sel == 2'd1) begin
            enq_push(pc_cur); enq_load(16'h0038);
        end else begin
            base = {page_reg, vec_byte & 8'hFE};
            enq_push(pc_cur);
            e = busy_rec(); e.rd = 1'b1; e.raddr = base; q.push_back(e);
            e.raddr = base + 16'd1; q.push_back(e);
            enq_load({mem_byte(base + 16'd1), mem_byte(base)});
        end
    endfunction

    // reference model, updated at the same edge the design samples
    always @(posedge clk) begin
        exp_t drop;
        bit took_n;
        cyc++;
        if (!rst_n) begin
            q.delete(); m_main = 0; m_shadow = 0; m_hold = 0; m_pend = 0; m_prev = 0;
        end else begin
            took_n = 0;
            if (q.size() != 0) begin
                drop = q.pop_front();
            end else begin
                if (insn_boundary && m_pend) begin
                    took_n = 1; m_shadow = m_main; m_main = 0;
                    enq_push(pc_cur); enq_load(16'h0066);
                end else if (insn_boundary && m_main && int_req && !m_hold) begin
                    m_main = 0; m_shadow = 0; enq_int();
                end else if (ei_cmd) begin
                    m_main = 1; m_shadow = 1;
                end else if (di_cmd) begin
                    m_main = 0; m_shadow = 0;
                end else if (nmi_return) begin
                    m_main = m_shadow;
                end
                if (ei_cmd) m_hold = 1;
                else if (insn_boundary) m_hold = 0;
            end
            m_pend = (m_pend && !took_n) || (nmi_req && !m_prev);
            m_prev = nmi_req;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        exp_t e, got;
        if (running && !done) begin
            e = (q.size() != 0) ? q[0] : '0;
            got.busy = busy; got.ackio = ack_io_req; got.ackm1 = ack_opfetch;
            got.push = push_req; got.pdata = push_data; got.rd = tbl_rd;
            got.raddr = tbl_addr; got.load = pc_load; got.pcnew = pc_new;
            got.rv = insn_valid; got.rbyte = insn_byte;
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s cycle %0d outputs: actual %h expected %h", cur_req, cyc, got, e);
            end
            checks++;
            if ({en_main, en_shadow} !== {m_main, m_shadow}) begin
                fails++;
                $display("FAIL %s cycle %0d flags: actual %b%b expected %b%b",
                         cur_req, cyc, en_main, en_shadow, m_main, m_shadow);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bnd();
        insn_boundary = 1; @(negedge clk); insn_boundary = 0;
    endtask

    task automatic pulse_ei();
        ei_cmd = 1; @(negedge clk); ei_cmd = 0;
    endtask

    task automatic pulse_di();
        di_cmd = 1; @(negedge clk); di_cmd = 0;
    endtask

    task automatic pulse_ret();
        nmi_return = 1; @(negedge clk); nmi_return = 0;
    endtask

    task automatic pulse_nmi();
        nmi_req = 1; @(negedge clk); nmi_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL %s watchdog: actual still running, expected finished", cur_req);
            finish_run();
        end
    end

    initial begin
        @(posedge clk);
        running = 1;
        idle_cycles(3);
        rst_n = 1;
        cur_req = "R1"; idle_cycles(3);

        // R4: maskable request while disabled has no effect
        cur_req = "R4"; int_req = 1; im_sel = 1; pc_cur = 16'h4321;
        bnd(); idle_cycles(4); int_req = 0;

        // R3: non-maskable entry from disabled state
        cur_req = "R3"; pc_cur = 16'h1234; pulse_nmi(); idle_cycles(2);
        bnd(); idle_cycles(6);

        // R9 then R7 and R5: enable hold-off, then fixed-address entry
        cur_req = "R9"; pulse_ei(); int_req = 1; pc_cur = 16'hABCD; bnd(); idle_cycles(2);
        cur_req = "R7"; bnd(); int_req = 0; idle_cycles(7);

        // R6: instruction byte hand-back
        cur_req = "R6"; im_sel = 0; vec_byte = 8'hFF; pulse_ei(); int_req = 1;
        bnd(); idle_cycles(1); bnd(); int_req = 0; idle_cycles(5);

        // R8 with odd device byte, and R11 command during busy ignored
        cur_req = "R8"; im_sel = 2; page_reg = 8'h12; vec_byte = 8'h37; pc_cur = 16'h5A5A;
        pulse_ei(); int_req = 1; bnd(); idle_cycles(1); bnd(); int_req = 0;
        cur_req = "R11"; pulse_ei(); pulse_di(); idle_cycles(8);

        // R8 with im_sel = 3
        cur_req = "R8"; im_sel = 3; page_reg = 8'h80; vec_byte = 8'hFE; pc_cur = 16'h0F0F;
        pulse_ei(); int_req = 1; bnd(); idle_cycles(1); bnd(); int_req = 0; idle_cycles(9);

        // R3 and R10: shadow flag keeps enabled state, return restores it
        cur_req = "R3"; pulse_ei(); bnd(); pc_cur = 16'h2222;
        pulse_nmi(); idle_cycles(1); bnd(); idle_cycles(6);
        cur_req = "R10"; pulse_ret(); idle_cycles(2);

        // R2: non-maskable wins over maskable at the same boundary
        cur_req = "R2"; im_sel = 1; int_req = 1; pc_cur = 16'h3333;
        pulse_nmi(); idle_cycles(1); bnd(); idle_cycles(6); int_req = 0;
        pulse_ret(); idle_cycles(2);

        // R10: disable clears both flags; maskable request then ignored
        cur_req = "R10"; pulse_di(); int_req = 1; bnd(); idle_cycles(4); int_req = 0;

        // R2: held level does not retrigger
        cur_req = "R2"; nmi_req = 1; idle_cycles(2); bnd(); idle_cycles(6);
        bnd(); idle_cycles(4); nmi_req = 0; idle_cycles(2);

        // R2: edge during a busy entry stays pending
        pc_cur = 16'h7777; pulse_nmi(); idle_cycles(1); bnd(); pulse_nmi();
        idle_cycles(6); bnd(); idle_cycles(6);

        finish_run();
    end
endmodule